// File: doc/BRIEF.md
# Open-Drain Channel Direction Arbiter

This block is the digital control for one bidirectional, wired-low data channel that links a host-side terminal to a card-side terminal. Each terminal is seen as a sampled input level plus an output enable that actively pulls that terminal low. There is no direction pin. While the channel is idle, the arbiter watches both terminals. The first terminal seen falling becomes the driver, and the arbiter pulls the opposite terminal low for as long as the driver stays low.

When the driving terminal returns high, the arbiter stops pulling the follower. It then raises a short active pull-up assist pulse of a set number of clocks, which speeds up the rising edge, and goes back to idle. A channel enable turns the channel off. While it is off, the host terminal is left released and the card terminal is held low. Both inputs pass through a synchroniser before any edge is detected. The channel is meant for signalling at up to 1 MHz, well below the system clock.

Top module: `dda_arbiter`

## Requirements
- R1: After reset with the channel enabled and both terminals high, `host_pull_lo`, `card_pull_lo` and `pu_boost` are all 0.
- R2: A host-side fall seen in idle asserts `card_pull_lo` after the third rising clock edge that follows the input change (two synchroniser stages plus the state register). `host_pull_lo` stays 0.
- R3: A card-side fall seen in idle asserts `host_pull_lo` after the third rising edge that follows the input change. `card_pull_lo` stays 0.
- R4: If both terminals fall in the same clock cycle, the host side wins, so `card_pull_lo` is asserted and `host_pull_lo` is not.
- R5: While one side drives, any falling or rising activity on the follower terminal leaves all three outputs unchanged.
- R6: When the driving terminal returns high, the follower pull is removed after the third rising edge that follows the input change.
- R7: `pu_boost` is asserted for exactly `PULSE_CYC` cycles. It starts in the same cycle that the follower pull is removed, and it is never high at the same time as either pull output. After the pulse, the channel is idle.
- R8: While `chan_en` is 0, the outputs are `card_pull_lo`=1, `host_pull_lo`=0 and `pu_boost`=0, with no clock edge needed. Falls during that time are ignored. A terminal that is still low when the channel is re-enabled does not start a transfer.
- R9: Turning `chan_en` off while a side drives ends the transfer without any assist pulse. After re-enabling, a fresh fall is arbitrated normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; 0 turns the channel off |
| host_in | input | 1 | Sampled level of the host-side terminal |
| card_in | input | 1 | Sampled level of the card-side terminal |
| host_pull_lo | output | 1 | Pulls the host-side terminal low |
| card_pull_lo | output | 1 | Pulls the card-side terminal low |
| pu_boost | output | 1 | Active pull-up assist pulse on release |

## Verification
The bench builds the arbiter with `PULSE_CYC`=3 and the default two synchroniser stages. With these values, a pulse of more than one cycle can be told apart from a stuck or one-cycle pulse, and the three-edge latency stays short enough to count directly.

The bench models each terminal as a wired-low line, driven both by an external device and by the arbiter's own pull. It sweeps the offset between the host fall and the card fall from three cycles card-first to three cycles host-first, which includes the same-cycle tie. For every offset it follows the full sequence through follower activity, release and the assist pulse. It then turns the channel off, both while idle and in the middle of a transfer.

// File: rtl/dda_pkg.sv
package dda_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOST  = 2'd1,
    ST_CARD  = 2'd2,
    ST_BOOST = 2'd3
  } dda_state_e;

  // Arbitration out of idle: host side has priority on a tie.
  function automatic dda_state_e pick_driver(logic host_fall, logic card_fall);
    if (host_fall)      return ST_HOST;
    else if (card_fall) return ST_CARD;
    else                return ST_IDLE;
  endfunction

  // True on the final cycle of the assist pulse.
  function automatic logic boost_last(int unsigned cnt, int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/dda_sync.sv
module dda_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dda_edge.sv
module dda_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chk
    // R2
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall[g] |=> !fall[g]);
  end

endmodule

// File: rtl/dda_fsm.sv
module dda_fsm
  import dda_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       host_fall,
  input  logic       card_fall,
  input  logic       host_hi,
  input  logic       card_hi,
  output dda_state_e st
);

  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          last_w;

  assign last_w = boost_last(32'(cnt_q), PULSE_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st    <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          st    <= pick_driver(host_fall, card_fall);
          cnt_q <= '0;
        end
        ST_HOST: if (host_hi) begin
          st    <= ST_BOOST;
          cnt_q <= '0;
        end
        ST_CARD: if (card_hi) begin
          st    <= ST_BOOST;
          cnt_q <= '0;
        end
        ST_BOOST: begin
          if (last_w) st    <= ST_IDLE;
          else        cnt_q <= cnt_q + CW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  tie_host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_IDLE && host_fall && card_fall) |=> st == ST_HOST);

  // R5
  host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_HOST && !host_hi) |=> st == ST_HOST);

  // R5
  card_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_CARD && !card_hi) |=> st == ST_CARD);

  // R6
  host_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_HOST && host_hi) |=> st == ST_BOOST);

  // R7
  boost_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BOOST) |-> (32'(cnt_q) < PULSE_CYC));

  // R7
  boost_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_BOOST && last_w) |=> st == ST_IDLE);

  // R8
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st == ST_IDLE);

endmodule

// File: rtl/dda_arbiter.sv
module dda_arbiter
  import dda_pkg::*;
#(
  parameter int PULSE_CYC   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic host_in,
  input  logic card_in,
  output logic host_pull_lo,
  output logic card_pull_lo,
  output logic pu_boost
);

  localparam int NSIDE = 2;  // bit 1 host, bit 0 card

  logic [NSIDE-1:0] lvl_s;
  logic [NSIDE-1:0] fall_s;
  dda_state_e       st;

  dda_sync #(.WIDTH(NSIDE), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({host_in, card_in}),
    .q    (lvl_s)
  );

  dda_edge #(.WIDTH(NSIDE)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl_s),
    .fall (fall_s)
  );

  dda_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (chan_en),
    .host_fall(fall_s[1]),
    .card_fall(fall_s[0]),
    .host_hi  (lvl_s[1]),
    .card_hi  (lvl_s[0]),
    .st       (st)
  );

  assign host_pull_lo = chan_en && (st == ST_CARD);
  assign card_pull_lo = !chan_en || (st == ST_HOST);
  assign pu_boost     = chan_en && (st == ST_BOOST);

  // R7
  boost_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pu_boost |-> (!host_pull_lo && !card_pull_lo));

  // R2
  no_both_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pull_lo && card_pull_lo));

endmodule

// File: tb/tb_dda_arbiter.sv
`timescale 1ns/1ps
module tb_dda_arbiter;

  localparam int P   = 3;  // assist pulse length under test
  localparam int LAT = 3;  // two sync stages + state register

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b1;
  logic host_dev = 1'b0;  // 1 = external device pulls host line low
  logic card_dev = 1'b0;
  logic host_pull_lo, card_pull_lo, pu_boost;
  logic host_line, card_line;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  assign host_line = ~host_dev & ~host_pull_lo;
  assign card_line = ~card_dev & ~card_pull_lo;

  dda_arbiter #(.PULSE_CYC(P)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .host_in     (host_line),
    .card_in     (card_line),
    .host_pull_lo(host_pull_lo),
    .card_pull_lo(card_pull_lo),
    .pu_boost    (pu_boost)
  );

  // expected vectors {host_pull_lo, card_pull_lo, boost}
  localparam logic [2:0] V_IDLE = 3'b000;
  localparam logic [2:0] V_HOST = 3'b010;  // host drives, card follows
  localparam logic [2:0] V_CARD = 3'b100;
  localparam logic [2:0] V_BST  = 3'b001;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {host_pull_lo, card_pull_lo, pu_boost};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // d >= 0: host falls first, card d cycles later; d < 0: card first.
  task automatic run_pair(int d);
    bit host_wins;
    int ad;
    logic [2:0] win;
    host_wins = (d >= 0);
    ad  = (d < 0) ? -d : d;
    win = host_wins ? V_HOST : V_CARD;
    if (host_wins) host_dev = 1'b1; else card_dev = 1'b1;
    if (d == 0) card_dev = 1'b1;
    for (int t = 1; t <= 6; t++) begin
      step(1);
      if (t == ad && d != 0) begin
        if (host_wins) card_dev = 1'b1; else host_dev = 1'b1;
      end
      if (t == LAT - 1) chk(d == 0 ? "R4 pre" : (host_wins ? "R2 pre" : "R3 pre"), V_IDLE);
      if (t >= LAT) chk(d == 0 ? "R4 win" : (host_wins ? "R2 win" : "R3 win"), win);
    end
    // follower activity must not change anything
    if (host_wins) card_dev = 1'b0; else host_dev = 1'b0;
    step(2); chk("R5 follower release", win);
    if (host_wins) card_dev = 1'b1; else host_dev = 1'b1;
    step(3); chk("R5 follower refall", win);
    if (host_wins) card_dev = 1'b0; else host_dev = 1'b0;
    step(3); chk("R5 follower rise", win);
    // driver releases
    if (host_wins) host_dev = 1'b0; else card_dev = 1'b0;
    for (int t = 1; t <= LAT + P + 1; t++) begin
      step(1);
      if (t < LAT) chk("R6 still held", win);
      else if (t < LAT + P) chk("R7 boost", V_BST);
      else chk("R7 back idle", V_IDLE);
    end
    step(3);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(2);
    chk("R1 reset idle", V_IDLE);

    for (int d = -3; d <= 3; d++) run_pair(d);

    // R8 disabled while idle
    chan_en = 1'b0;
    step(1); chk("R8 off holds card low", V_HOST);
    host_dev = 1'b1;
    step(5); chk("R8 fall ignored while off", V_HOST);
    chan_en = 1'b1;
    step(1); chk("R8 reenable idle", V_IDLE);
    step(5); chk("R8 stale low ignored", V_IDLE);
    host_dev = 1'b0;
    step(4);
    host_dev = 1'b1;
    step(LAT); chk("R8 resume host drive", V_HOST);
    host_dev = 1'b0;
    step(LAT + P + 2); chk("R8 resume back idle", V_IDLE);

    // R9 disable during a card-driven transfer
    card_dev = 1'b1;
    step(LAT); chk("R9 card drives", V_CARD);
    chan_en = 1'b0;
    step(1); chk("R9 off mid transfer", V_HOST);
    card_dev = 1'b0;
    step(3);
    chan_en = 1'b1;
    for (int t = 1; t <= 4; t++) begin
      step(1); chk("R9 no assist after off", V_IDLE);
    end
    card_dev = 1'b1;
    step(LAT); chk("R9 fresh card fall", V_CARD);
    card_dev = 1'b0;
    step(LAT + P + 2); chk("R9 fresh back idle", V_IDLE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule